// File: doc/BRIEF.md
# Instruction-Rate Running Light

This block drives a bank of eight LEDs as a running light whose speed follows how fast the processor fetches opcodes. Every cycle in which the opcode-fetch strobe is high counts as one fetch. Each byte of a multi-byte instruction is a separate fetch, so the light runs slightly faster than the true instruction rate. Under normal clock settings, the lit position moves one step after a fixed number of counted fetches. After eight steps the light has gone once round the ring.

When the clock prescaler is set very slow, waiting for thousands of fetches would freeze the light. In that case the light moves one step on every single fetch. The lowest LED does not belong to the ring: it shows a separate flag that reports that the boot firmware context is active. The running point spends one of its eight positions on that LED, and during that position none of the seven ring LEDs is lit.

Top module: `lri_run_light`

## Requirements
- R1: A synchronous reset, held for at least one rising edge, sets the step position and the fetch count to zero. After reset, `leds[7:1]` is all zero.
- R2: When `prescale` is below 24'h0FFFFF, the position advances by one on the clock edge that registers the 62,500th counted fetch since the last advance.
- R3: At most one bit of `leds[7:1]` is high. Bit `leds[p]` is high exactly when the position is p, for p from 1 to 7. Position 0 lights none of them.
- R4: `leds[0]` equals `ctx_active` in the same cycle, with no register in between, whatever the position.
- R5: A cycle with `fetch` low leaves the position and the fetch count unchanged.
- R6: When `prescale` is 24'h0FFFFF or higher, up to 24'hFFFFFF, each fetch advances the position by one on that clock edge.
- R7: The position wraps from 7 to 0, so eight advances bring it back to where it started.
- R8: A fetch taken while `prescale` is 24'h0FFFFF or higher clears the partial fetch count. After returning to a lower `prescale`, a full 62,500 fetches are needed for the next advance.
- R9: After an advance in counting mode, the fetch count restarts at zero and never exceeds 62,499.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch | input | 1 | High for one cycle per opcode fetch |
| prescale | input | 24 | Current clock prescaler setting |
| ctx_active | input | 1 | Boot-firmware context flag, passed through to the LED 0 output |
| leds | output | 8 | Bit 0 is the context flag; bits 7:1 form the running light |

## Verification
The assertions assume that `fetch` reports one fetch per high cycle, so back-to-back high cycles count as separate fetches. They also assume that `prescale` may change in any cycle, including between two fetches. The stimulus drives every input on the falling edge. It switches `prescale` freely between values just below the threshold, the threshold itself, random values on either side and the all-ones value. It toggles `ctx_active` at random. Long directed runs cover the exact 62,500-fetch boundary. The random phases stay mostly in slow mode so that many steps and wraps occur within the cycle budget.

// File: rtl/lri_pkg.sv
package lri_pkg;

    typedef enum logic {
        MODE_COUNT  = 1'b0,
        MODE_DIRECT = 1'b1
    } step_mode_e;

endpackage

// File: rtl/lri_rate_div.sv
module lri_rate_div
    import lri_pkg::*;
#(
    parameter int unsigned STEP_FETCHES = 62500,
    parameter int unsigned PRESC_W      = 24,
    parameter logic [PRESC_W-1:0] SLOW_FLOOR = 24'h0FFFFF,
    localparam int unsigned CNT_W = $clog2(STEP_FETCHES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               step_o,
    output step_mode_e         mode_o,
    output logic [CNT_W-1:0]   cnt_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_FETCHES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    step_mode_e mode_d;
    logic       last_d;
    logic       step_d;

    always_comb begin
        st_d   = st_q;
        mode_d = (presc_i >= SLOW_FLOOR) ? MODE_DIRECT : MODE_COUNT;
        last_d = (st_q.cnt == CNT_LAST);
        step_d = 1'b0;
        if (fetch_i) begin
            if (mode_d == MODE_DIRECT) begin
                st_d.cnt = '0;
                step_d   = 1'b1;
            end else if (last_d) begin
                st_d.cnt = '0;
                step_d   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign step_o = step_d;
    assign mode_o = mode_d;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/lri_pos_ring.sv
module lri_pos_ring #(
    parameter int unsigned LED_N = 8,
    localparam int unsigned POS_W = $clog2(LED_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(LED_N - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } ring_state_t;

    ring_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (st_q.pos == POS_LAST) st_d.pos = '0;
            else                      st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pos_o = st_q.pos;

endmodule

// File: rtl/lri_led_map.sv
module lri_led_map #(
    parameter int unsigned LED_N = 8,
    localparam int unsigned POS_W = $clog2(LED_N)
) (
    input  logic             ctx_i,
    input  logic [POS_W-1:0] pos_i,
    output logic [LED_N-1:0] leds_o
);

    assign leds_o[0] = ctx_i;

    for (genvar i = 1; i < LED_N; i++) begin : g_ring
        assign leds_o[i] = (pos_i == POS_W'(i));
    end

endmodule

// File: rtl/lri_run_light.sv
module lri_run_light
    import lri_pkg::*;
#(
    parameter int unsigned STEP_FETCHES = 62500,
    parameter int unsigned PRESC_W      = 24,
    parameter logic [PRESC_W-1:0] SLOW_FLOOR = 24'h0FFFFF,
    parameter int unsigned LED_N        = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch,
    input  logic [PRESC_W-1:0] prescale,
    input  logic               ctx_active,
    output logic [LED_N-1:0]   leds
);

    localparam int unsigned CNT_W = $clog2(STEP_FETCHES);
    localparam int unsigned POS_W = $clog2(LED_N);

    logic             step_w;
    step_mode_e       mode_w;
    logic [CNT_W-1:0] cnt_w;
    logic [POS_W-1:0] pos_w;

    lri_rate_div #(
        .STEP_FETCHES(STEP_FETCHES),
        .PRESC_W     (PRESC_W),
        .SLOW_FLOOR  (SLOW_FLOOR)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .fetch_i(fetch),
        .presc_i(prescale),
        .step_o (step_w),
        .mode_o (mode_w),
        .cnt_o  (cnt_w)
    );

    lri_pos_ring #(
        .LED_N(LED_N)
    ) u_ring (
        .clk   (clk),
        .rst   (rst),
        .step_i(step_w),
        .pos_o (pos_w)
    );

    lri_led_map #(
        .LED_N(LED_N)
    ) u_map (
        .ctx_i (ctx_active),
        .pos_i (pos_w),
        .leds_o(leds)
    );

endmodule

// File: rtl/lri_run_light_chk.sv
module lri_run_light_chk #(
    parameter int unsigned STEP_FETCHES = 62500,
    parameter int unsigned PRESC_W      = 24,
    parameter logic [PRESC_W-1:0] SLOW_FLOOR = 24'h0FFFFF,
    parameter int unsigned LED_N        = 8,
    localparam int unsigned CNT_W = $clog2(STEP_FETCHES),
    localparam int unsigned POS_W = $clog2(LED_N)
) (
    input logic               clk,
    input logic               rst,
    input logic               fetch,
    input logic [PRESC_W-1:0] prescale,
    input logic               ctx_active,
    input logic [LED_N-1:0]   leds,
    input logic [CNT_W-1:0]   cnt_w,
    input logic [POS_W-1:0]   pos_w
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (cnt_w == '0 && pos_w == '0)) else $error("reset state"); // R1

    AST_ONE_RUNNER: assert property (@(posedge clk) disable iff (rst)
        $countones(leds[LED_N-1:1]) <= 1) else $error("ring not one-hot"); // R3

    AST_CTX_PASS: assert property (@(posedge clk) disable iff (rst)
        leds[0] == ctx_active) else $error("context led"); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fetch |=> ($stable(pos_w) && $stable(cnt_w))) else $error("idle change"); // R5

    AST_SLOW_STEP: assert property (@(posedge clk) disable iff (rst)
        (fetch && prescale >= SLOW_FLOOR) |=>
            (pos_w == POS_W'($past(pos_w) + 1'b1) && cnt_w == '0)) else $error("slow step"); // R6

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_w <= CNT_W'(STEP_FETCHES - 1)) else $error("count bound"); // R9

    AST_COUNT_HOLDS_POS: assert property (@(posedge clk) disable iff (rst)
        (fetch && prescale < SLOW_FLOOR && cnt_w != CNT_W'(STEP_FETCHES - 1)) |=>
            $stable(pos_w)) else $error("early step"); // R2

endmodule

bind lri_run_light lri_run_light_chk #(
    .STEP_FETCHES(STEP_FETCHES),
    .PRESC_W     (PRESC_W),
    .SLOW_FLOOR  (SLOW_FLOOR),
    .LED_N       (LED_N)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fetch     (fetch),
    .prescale  (prescale),
    .ctx_active(ctx_active),
    .leds      (leds),
    .cnt_w     (cnt_w),
    .pos_w     (pos_w)
);

// File: tb/lri_run_light_test.sv
module lri_run_light_test;

    localparam int STEP = 62500;
    localparam logic [23:0] FLOOR = 24'h0FFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch = 1'b0;
    logic [23:0] prescale = 24'h0;
    logic        ctx_active = 1'b0;
    logic [7:0]  leds;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    int m_pos = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lri_run_light uut (
        .clk(clk), .rst(rst), .fetch(fetch), .prescale(prescale),
        .ctx_active(ctx_active), .leds(leds)
    );

    function automatic logic [7:0] exp_leds(int pos, logic ctx);
        logic [7:0] v;
        v = 8'h00;
        if (pos != 0) v[pos] = 1'b1;
        v[0] = ctx;
        return v;
    endfunction

    task automatic check(string req);
        logic [7:0] e;
        e = exp_leds(m_pos, ctx_active);
        checks++;
        if (leds !== e) begin
            errors++;
            $display("FAIL %s leds actual=%b expected=%b", req, leds, e);
        end
    endtask

    // one clock: drive at negedge, model the edge, return at next negedge
    task automatic tick(logic f, logic [23:0] p);
        fetch = f;
        prescale = p;
        if (f) begin
            if (p >= FLOOR) begin
                m_cnt = 0;
                m_pos = (m_pos + 1) % 8;
            end else if (m_cnt == STEP - 1) begin
                m_cnt = 0;
                m_pos = (m_pos + 1) % 8;
            end else begin
                m_cnt++;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [23:0] pick_presc();
        case ($urandom % 6)
            0: return 24'h0FFFFE;
            1: return 24'h0FFFFF;
            2: return 24'hFFFFFF;
            3: return FLOOR + 24'($urandom % 24'hF00000);
            4: return FLOOR + 24'($urandom % 24'hF00000);
            default: return 24'($urandom % 24'h0FFFFF);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1");
        ctx_active = 1'b1;
        #1 check("R4");
        ctx_active = 1'b0;
        #1 check("R4");

        // R2: 62,499 fetches must not move the light, the next one must
        for (int i = 0; i < STEP - 1; i++) tick(1'b1, 24'h000123);
        check("R2 no early step");
        tick(1'b0, 24'h000123);
        check("R5 idle");
        tick(1'b1, 24'h0FFFFE);
        check("R2 step at boundary");

        // R9: count restarted; R8: slow fetch clears partial count
        for (int i = 0; i < STEP - 100; i++) tick(1'b1, 24'h000000);
        check("R9 restart from zero");
        tick(1'b1, 24'h0FFFFF);
        check("R6 threshold fetch");
        for (int i = 0; i < 200; i++) tick(1'b1, 24'h0FFFFE);
        check("R8 partial count cleared");

        // R7 / R6: full revolution in slow mode
        begin
            int start;
            start = m_pos;
            for (int i = 0; i < 8; i++) begin
                tick(1'b1, 24'hFFFFFF);
                check("R6 per fetch");
            end
            checks++;
            if (m_pos != start) begin
                errors++;
                $display("FAIL R7 model pos actual=%0d expected=%0d", m_pos, start);
            end
            check("R7 wrap");
        end

        // reset mid-run
        tick(1'b1, 24'hFFFFFF);
        rst = 1'b1;
        m_pos = 0;
        m_cnt = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-run");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            ctx_active = 1'($urandom % 2);
            tick(1'($urandom % 2), pick_presc());
            check("R3 R5 R6 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule